// File: doc/BRIEF.md
# Multicore Debug Halt Propagation Unit

This cluster-level unit makes a group of cores stop together under a debugger. Every core reports halt events, each tagged with a two-bit cause code. When a core in the selected group halts for a cause that software has enabled, the unit raises a halt request to every other core in the group. Each request stays high until that core signals that it has resumed. A core that is outside the group, or an event whose cause is disabled, starts nothing.

The unit also owns a 64-bit global free-running counter that is shared by the cluster. The counter stops while any core named in a separate counter-freeze mask is halted. This lets timestamps stay consistent across a debug stop. Software reaches the unit through a command port: an opcode, a small parameter field and a data word, with a registered readback word for read commands. The commands that touch the counter-freeze mask exist only when the counter's version parameter is 3 or higher. On older versions those commands do nothing.

Top module: `halt_fanout_unit`

## Requirements
- R1: While reset is low, and on the first cycle after it, `haltReq`, `rdData`, `cntValue` and all three masks are zero.
- R2: Opcode 1 writes `cmdData[NUM_CORES-1:0]` into the core-select mask. Bit i stands for core i. Opcode 2 copies that mask, zero-extended, into `rdData` at the next clock edge.
- R3: Opcode 3 takes the cause-enable mask from `cmdParam[3:0]` and the core-select mask from `cmdData`. Opcode 4 returns the core-select mask through `rdData`, the same way opcode 2 does.
- R4: Core i reports its cause on `haltCause[2i+1:2i]`. The codes are 0 for the status halt flag, 1 for an actionpoint, 2 for a breakpoint and 3 for a self-halt. Bit k of the cause-enable mask enables code k, and 0xF enables all four.
- R5: A `haltEvt` pulse from a selected core with an enabled cause sets `haltReq` at the next edge for every other selected core. It does not set the request of the core that halted.
- R6: An event from an unselected core, or one carrying a disabled cause, changes no `haltReq` bit.
- R7: A set `haltReq[j]` stays high until `coreResume[j]`, and it clears at that edge. If a new propagation targets core j in the same cycle, the request stays set.
- R8: The counter resets to zero and, while `cntEnable` is high, increments by one at each edge.
- R9: `cntEnable` is low, and `cntValue` holds, while any core whose bit is set in the counter-freeze mask has `coreHalted` high.
- R10: With CNT_VER >= 3, opcode 5 writes the counter-freeze mask from `cmdData` and opcode 6 reads it back through `rdData`. With CNT_VER < 3, both opcodes leave the mask at zero and `rdData` unchanged.
- R11: Opcodes 0, 7 and above, and commands with `cmdValid` low, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe, one cycle per command |
| cmdOp | input | 4 | Command opcode |
| cmdParam | input | PARAM_W | Command parameter field (cause-enable mask) |
| cmdData | input | DATA_W | Command data word (core masks) |
| rdData | output | DATA_W | Readback register |
| haltEvt | input | NUM_CORES | Per-core halt event pulse |
| haltCause | input | 2*NUM_CORES | Per-core cause code for the halt event |
| coreHalted | input | NUM_CORES | Per-core level, high while the core is halted |
| coreResume | input | NUM_CORES | Per-core resume pulse |
| haltReq | output | NUM_CORES | Per-core halt request |
| cntEnable | output | 1 | Global counter is running |
| cntValue | output | CNT_W | Global counter value |

## Verification
The hardest case to reach from the ports is a core whose request is still held when a second propagation hits it in the same cycle as its own resume pulse. Random stimulus rarely lines up those three things. A directed step therefore builds exactly that overlap, and constrained random cycles then mix sparse events, resumes, halted levels and commands, including unknown opcodes. A second instance built with an old counter version takes the same traffic. This shows that the freeze-mask commands have no effect there while its counter keeps running.

// File: rtl/halt_fanout_pkg.sv
package halt_fanout_pkg;

  localparam int CAUSE_W   = 2;
  localparam int CAUSE_NUM = 1 << CAUSE_W;
  localparam int OP_W      = 4;

  typedef enum logic [OP_W-1:0] {
    OP_NOP      = 4'd0,
    OP_SEL_WR   = 4'd1,
    OP_SEL_RD   = 4'd2,
    OP_MASK_WR  = 4'd3,
    OP_MASK_RD  = 4'd4,
    OP_CMASK_WR = 4'd5,
    OP_CMASK_RD = 4'd6
  } haltOpE;

  typedef struct packed {
    logic wrSel;
    logic wrCause;
    logic wrCntMask;
    logic rdSel;
    logic rdCntMask;
  } haltStrobeT;

endpackage

// File: rtl/halt_fanout_ctrl.sv
module halt_fanout_ctrl
  import halt_fanout_pkg::*;
#(
  parameter int CNT_VER = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmdValid,
  input  logic [OP_W-1:0] cmdOp,
  output haltStrobeT      strb
);

  localparam bit HAS_CMASK = (CNT_VER >= 3);

  haltStrobeT baseStrb;

  always_comb begin
    baseStrb = '0;
    if (cmdValid) begin
      case (haltOpE'(cmdOp))
        OP_SEL_WR:   baseStrb.wrSel     = 1'b1;
        OP_SEL_RD:   baseStrb.rdSel     = 1'b1;
        OP_MASK_WR:  begin
          baseStrb.wrSel   = 1'b1;
          baseStrb.wrCause = 1'b1;
        end
        OP_MASK_RD:  baseStrb.rdSel     = 1'b1;
        OP_CMASK_WR: baseStrb.wrCntMask = 1'b1;
        OP_CMASK_RD: baseStrb.rdCntMask = 1'b1;
        default:     baseStrb = '0;
      endcase
    end
  end

  generate
    if (HAS_CMASK) begin : g_cmask
      assign strb = baseStrb;
    end else begin : g_nocmask
      always_comb begin
        strb           = baseStrb;
        strb.wrCntMask = 1'b0;
        strb.rdCntMask = 1'b0;
      end
    end
  endgenerate

  // R11: idle port or unknown opcode raises no strobe
  assert_unknown_op_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmdValid || cmdOp == 4'd0 || cmdOp > 4'd6) |-> (strb == '0));

endmodule

// File: rtl/halt_fanout_dp.sv
module halt_fanout_dp
  import halt_fanout_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int CNT_W     = 64,
  parameter int DATA_W    = 32,
  parameter int PARAM_W   = 8,
  parameter int CNT_VER   = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  haltStrobeT                   strb,
  input  logic [PARAM_W-1:0]           cmdParam,
  input  logic [DATA_W-1:0]            cmdData,
  input  logic [NUM_CORES-1:0]         haltEvt,
  input  logic [CAUSE_W*NUM_CORES-1:0] haltCause,
  input  logic [NUM_CORES-1:0]         coreHalted,
  input  logic [NUM_CORES-1:0]         coreResume,
  output logic [NUM_CORES-1:0]         haltReq,
  output logic                         cntEnable,
  output logic [CNT_W-1:0]             cntValue,
  output logic [DATA_W-1:0]            rdData
);

  logic [NUM_CORES-1:0] selMask;
  logic [NUM_CORES-1:0] cntHaltMask;
  logic [CAUSE_NUM-1:0] causeMask;
  logic [NUM_CORES-1:0] causeOk;
  logic [NUM_CORES-1:0] trigVec;
  logic [NUM_CORES-1:0] setVec;
  logic [NUM_CORES-1:0] otherVec [NUM_CORES];
  logic                 cntFreeze;

  // cause filter per core
  generate
    for (genvar i = 0; i < NUM_CORES; i++) begin : g_cause
      assign causeOk[i] = causeMask[haltCause[CAUSE_W*i +: CAUSE_W]];
    end
  endgenerate

  assign trigVec = haltEvt & selMask & causeOk;

  // fan-out: each selected core is hit by any trigger other than its own
  generate
    for (genvar j = 0; j < NUM_CORES; j++) begin : g_fan
      always_comb begin
        otherVec[j]    = trigVec;
        otherVec[j][j] = 1'b0;
      end
      assign setVec[j] = selMask[j] & (|otherVec[j]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      haltReq <= '0;
    end else begin
      haltReq <= setVec | (haltReq & ~coreResume);
    end
  end

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      selMask   <= '0;
      causeMask <= '0;
    end else begin
      if (strb.wrSel)   selMask   <= cmdData[NUM_CORES-1:0];
      if (strb.wrCause) causeMask <= cmdParam[CAUSE_NUM-1:0];
    end
  end

  generate
    if (CNT_VER >= 3) begin : g_cmask
      always_ff @(posedge clk) begin
        if (!rst_n)              cntHaltMask <= '0;
        else if (strb.wrCntMask) cntHaltMask <= cmdData[NUM_CORES-1:0];
      end
    end else begin : g_nocmask
      assign cntHaltMask = '0;
    end
  endgenerate

  // readback
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdData <= '0;
    end else if (strb.rdSel) begin
      rdData <= DATA_W'(selMask);
    end else if (strb.rdCntMask) begin
      rdData <= DATA_W'(cntHaltMask);
    end
  end

  // shared free-running counter
  assign cntFreeze = |(coreHalted & cntHaltMask);
  assign cntEnable = ~cntFreeze;

  always_ff @(posedge clk) begin
    if (!rst_n)         cntValue <= '0;
    else if (cntEnable) cntValue <= cntValue + CNT_W'(1);
  end

  // R6: a newly raised request only goes to a core that was selected
  assert_req_only_selected_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((haltReq & ~$past(haltReq)) & ~$past(selMask)) == '0);

  // R5: a newly raised request needs a halt event in the previous cycle
  assert_req_needs_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((haltReq & ~$past(haltReq)) != '0) |-> ($past(haltEvt) != '0));

  // R7: a request only drops on its own resume pulse
  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(haltReq) & ~$past(coreResume) & ~haltReq) == '0);

  // R8: the counter steps by one when enabled
  assert_cnt_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cntEnable |=> (cntValue == $past(cntValue) + CNT_W'(1)));

  // R9: the counter holds while frozen
  assert_cnt_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cntEnable |=> $stable(cntValue));

  generate
    if (CNT_VER < 3) begin : g_old_chk
      // R10: without freeze-mask support the counter never stops
      assert_old_never_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cntEnable);
    end
  endgenerate

endmodule

// File: rtl/halt_fanout_unit.sv
module halt_fanout_unit
  import halt_fanout_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int CNT_W     = 64,
  parameter int DATA_W    = 32,
  parameter int PARAM_W   = 8,
  parameter int CNT_VER   = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cmdValid,
  input  logic [3:0]                   cmdOp,
  input  logic [PARAM_W-1:0]           cmdParam,
  input  logic [DATA_W-1:0]            cmdData,
  output logic [DATA_W-1:0]            rdData,
  input  logic [NUM_CORES-1:0]         haltEvt,
  input  logic [2*NUM_CORES-1:0]       haltCause,
  input  logic [NUM_CORES-1:0]         coreHalted,
  input  logic [NUM_CORES-1:0]         coreResume,
  output logic [NUM_CORES-1:0]         haltReq,
  output logic                         cntEnable,
  output logic [CNT_W-1:0]             cntValue
);

  haltStrobeT strb;

  halt_fanout_ctrl #(
    .CNT_VER (CNT_VER)
  ) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .strb     (strb)
  );

  halt_fanout_dp #(
    .NUM_CORES (NUM_CORES),
    .CNT_W     (CNT_W),
    .DATA_W    (DATA_W),
    .PARAM_W   (PARAM_W),
    .CNT_VER   (CNT_VER)
  ) dp_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb       (strb),
    .cmdParam   (cmdParam),
    .cmdData    (cmdData),
    .haltEvt    (haltEvt),
    .haltCause  (haltCause),
    .coreHalted (coreHalted),
    .coreResume (coreResume),
    .haltReq    (haltReq),
    .cntEnable  (cntEnable),
    .cntValue   (cntValue),
    .rdData     (rdData)
  );

  // R1: outputs are cleared during reset
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (haltReq == '0 && rdData == '0 && cntValue == '0));

endmodule

// File: tb/halt_fanout_unit_tb_top.sv
`timescale 1ns/1ps
module halt_fanout_unit_tb_top;

  localparam int NC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmdValid = 1'b0;
  logic [3:0]  cmdOp = '0;
  logic [7:0]  cmdParam = '0;
  logic [31:0] cmdData = '0;
  logic [NC-1:0]   haltEvt = '0;
  logic [2*NC-1:0] haltCause = '0;
  logic [NC-1:0]   coreHalted = '0;
  logic [NC-1:0]   coreResume = '0;

  logic [31:0]   rdData [2];
  logic [NC-1:0] haltReq [2];
  logic          cntEnable [2];
  logic [63:0]   cntValue [2];

  always #4 clk = ~clk;

  halt_fanout_unit #(.CNT_VER(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdParam(cmdParam), .cmdData(cmdData), .rdData(rdData[0]),
    .haltEvt(haltEvt), .haltCause(haltCause), .coreHalted(coreHalted),
    .coreResume(coreResume), .haltReq(haltReq[0]), .cntEnable(cntEnable[0]),
    .cntValue(cntValue[0]));

  halt_fanout_unit #(.CNT_VER(2)) dut_old_i (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdParam(cmdParam), .cmdData(cmdData), .rdData(rdData[1]),
    .haltEvt(haltEvt), .haltCause(haltCause), .coreHalted(coreHalted),
    .coreResume(coreResume), .haltReq(haltReq[1]), .cntEnable(cntEnable[1]),
    .cntValue(cntValue[1]));

  // reference model state, index 0 = new version, 1 = old version
  logic [NC-1:0] mSel [2];
  logic [3:0]    mCause [2];
  logic [NC-1:0] mCmask [2];
  logic [NC-1:0] mReq [2];
  logic [63:0]   mCnt [2];
  logic [31:0]   mRd [2];

  int  nVec = 0;
  int  nFail = 0;
  bit  done = 1'b0;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    nVec++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int k = 0; k < 2; k++) begin
      mSel[k] = '0; mCause[k] = '0; mCmask[k] = '0;
      mReq[k] = '0; mCnt[k] = '0; mRd[k] = '0;
    end
  endtask

  // next state from current inputs, per the requirements
  task automatic modelStep();
    for (int k = 0; k < 2; k++) begin
      logic [NC-1:0] trig, nReq, nSel, nCmask;
      logic [3:0]    nCause;
      logic [31:0]   nRd;
      bit            ge3;
      ge3 = (k == 0);
      trig = '0;
      for (int i = 0; i < NC; i++)
        trig[i] = haltEvt[i] & mSel[k][i] & mCause[k][haltCause[2*i +: 2]];
      for (int j = 0; j < NC; j++) begin
        logic [NC-1:0] oth;
        oth = trig; oth[j] = 1'b0;
        nReq[j] = (mSel[k][j] & (|oth)) | (mReq[k][j] & ~coreResume[j]);
      end
      nSel = mSel[k]; nCause = mCause[k]; nCmask = mCmask[k]; nRd = mRd[k];
      if (cmdValid) begin
        case (cmdOp)
          4'd1: nSel = cmdData[NC-1:0];
          4'd2: nRd  = 32'(mSel[k]);
          4'd3: begin nSel = cmdData[NC-1:0]; nCause = cmdParam[3:0]; end
          4'd4: nRd  = 32'(mSel[k]);
          4'd5: if (ge3) nCmask = cmdData[NC-1:0];
          4'd6: if (ge3) nRd = 32'(mCmask[k]);
          default: ;
        endcase
      end
      if ((coreHalted & mCmask[k]) == '0) mCnt[k] = mCnt[k] + 64'd1;
      mReq[k] = nReq; mSel[k] = nSel; mCause[k] = nCause;
      mCmask[k] = nCmask; mRd[k] = nRd;
    end
  endtask

  task automatic drv(logic v, logic [3:0] op, logic [7:0] prm, logic [31:0] dat,
                     logic [NC-1:0] evt, logic [2*NC-1:0] cause,
                     logic [NC-1:0] hlt, logic [NC-1:0] res);
    cmdValid = v; cmdOp = op; cmdParam = prm; cmdData = dat;
    haltEvt = evt; haltCause = cause; coreHalted = hlt; coreResume = res;
  endtask

  // called at a negedge with inputs applied; checks through the next negedge
  task automatic cycle(string tag);
    #1;
    for (int k = 0; k < 2; k++)
      chk((coreHalted & mCmask[k]) != '0 ? "R9" : tag, "cntEnable",
          64'(cntEnable[k]), 64'((coreHalted & mCmask[k]) == '0));
    modelStep();
    @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      chk(tag, "haltReq", 64'(haltReq[k]), 64'(mReq[k]));
      chk(tag, "rdData", 64'(rdData[k]), 64'(mRd[k]));
      chk(tag, "cntValue", cntValue[k], mCnt[k]);
    end
  endtask

  task automatic idle(string tag, int n);
    for (int c = 0; c < n; c++) begin
      drv(0, 4'd0, 8'd0, 32'd0, '0, '0, '0, '0);
      cycle(tag);
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250611));
    modelReset();
    repeat (3) @(negedge clk);
    // R1: state during reset
    for (int k = 0; k < 2; k++) begin
      chk("R1", "haltReq", 64'(haltReq[k]), 64'd0);
      chk("R1", "rdData", 64'(rdData[k]), 64'd0);
      chk("R1", "cntValue", cntValue[k], 64'd0);
    end
    rst_n = 1'b1;
    idle("R1", 1);
    // R2: write core-select mask, read it back
    drv(1, 4'd1, 8'd0, 32'hFFFF_FFF7, '0, '0, '0, '0); cycle("R2");
    drv(1, 4'd2, 8'd0, 32'd0, '0, '0, '0, '0);         cycle("R2");
    chk("R2", "rdData literal", 64'(rdData[0]), 64'h7);
    // R3: enable all causes with select 1011, read via opcode 4
    drv(1, 4'd3, 8'hAF, 32'hB, '0, '0, '0, '0);        cycle("R3");
    drv(1, 4'd4, 8'd0, 32'd0, '0, '0, '0, '0);         cycle("R3");
    chk("R3", "rdData literal", 64'(rdData[0]), 64'hB);
    // R5: core 0 breakpoint -> requests to cores 1 and 3
    drv(0, 4'd0, 8'd0, 32'd0, 4'b0001, 8'b00_00_00_10, '0, '0); cycle("R5");
    chk("R5", "haltReq literal", 64'(haltReq[0]), 64'hA);
    // R7: hold, then release one at a time
    idle("R7", 3);
    drv(0, 4'd0, 8'd0, 32'd0, '0, '0, '0, 4'b0010); cycle("R7");
    chk("R7", "haltReq literal", 64'(haltReq[0]), 64'h8);
    drv(0, 4'd0, 8'd0, 32'd0, '0, '0, '0, 4'b1000); cycle("R7");
    // R4: only breakpoint enabled
    drv(1, 4'd3, 8'h04, 32'hB, '0, '0, '0, '0); cycle("R4");
    drv(0, 4'd0, 8'd0, 32'd0, 4'b0010, 8'b00_00_00_00, '0, '0); cycle("R4");
    chk("R4", "haltReq literal", 64'(haltReq[0]), 64'h0);
    drv(0, 4'd0, 8'd0, 32'd0, 4'b0010, 8'b00_00_10_00, '0, '0); cycle("R4");
    chk("R4", "haltReq literal", 64'(haltReq[0]), 64'h9);
    // R6: unselected core 2 with enabled cause
    drv(0, 4'd0, 8'd0, 32'd0, '0, '0, '0, 4'b1001); cycle("R6");
    drv(0, 4'd0, 8'd0, 32'd0, 4'b0100, 8'b00_10_00_00, '0, '0); cycle("R6");
    chk("R6", "haltReq literal", 64'(haltReq[0]), 64'h0);
    // R7: resume collides with a new propagation
    drv(0, 4'd0, 8'd0, 32'd0, 4'b0001, 8'b00_00_00_10, '0, '0); cycle("R7");
    drv(0, 4'd0, 8'd0, 32'd0, 4'b0001, 8'b00_00_00_10, '0, 4'b0010); cycle("R7");
    chk("R7", "haltReq literal", 64'(haltReq[0]), 64'hA);
    drv(0, 4'd0, 8'd0, 32'd0, '0, '0, '0, 4'b1010); cycle("R7");
    // R10/R9: freeze mask on core 2, halt core 2
    drv(1, 4'd5, 8'd0, 32'h4, '0, '0, '0, '0); cycle("R10");
    drv(1, 4'd6, 8'd0, 32'd0, '0, '0, '0, '0); cycle("R10");
    chk("R10", "rdData literal", 64'(rdData[0]), 64'h4);
    for (int c = 0; c < 4; c++) begin
      drv(0, 4'd0, 8'd0, 32'd0, '0, '0, 4'b0100, '0); cycle("R9");
    end
    drv(0, 4'd0, 8'd0, 32'd0, '0, '0, 4'b1011, '0); cycle("R8");
    // R11: unknown opcodes and idle-strobe commands
    drv(1, 4'd9, 8'hFF, 32'hFFFF_FFFF, '0, '0, '0, '0); cycle("R11");
    drv(0, 4'd1, 8'hFF, 32'h0, '0, '0, '0, '0);         cycle("R11");
    drv(1, 4'd7, 8'hFF, 32'h0, '0, '0, '0, '0);         cycle("R11");
    drv(1, 4'd2, 8'd0, 32'd0, '0, '0, '0, '0);          cycle("R11");
    chk("R11", "rdData literal", 64'(rdData[0]), 64'hB);
    // random traffic
    for (int c = 0; c < 3000; c++) begin
      logic v;
      v = ($urandom % 4) == 0;
      drv(v, 4'($urandom % 8), 8'($urandom), $urandom,
          4'($urandom & $urandom & $urandom), 8'($urandom),
          4'($urandom & $urandom), 4'($urandom & $urandom));
      cycle("R5");
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end

endmodule